// File: doc/BRIEF.md
# Clause-22 PHY Management Master

This block runs IEEE 802.3 clause-22 management frames to an external PHY under software control. Software loads a target descriptor (PHY address, register address and direction), plus a 16-bit payload for writes. It then sets the go/busy flag in the control register. The hardware shifts out one 64-bit frame on the serial management clock and data lines, and clears the flag when the frame is over. For a read, the 16 bits returned by the PHY land in a result register, which software reads once the flag is back at zero.

Software reaches the registers through a small word-select port. The read path is combinational and a write takes effect at the next clock edge. Select 0 is the descriptor, 1 the write payload, 2 the read result (read-only) and 3 the control register. The management clock is the system clock divided by an even parameter `CLK_DIV`, which defaults to 40. A global enable bit gates the whole serial interface.

Top module: `mdio_master`

## Requirements
- R1: Descriptor register (select 0) holds the register address in bits [4:0], the PHY address in bits [9:5] and the direction in bit 10 (1 = read, 0 = write). It reads back these 11 bits with zeros above them.
- R2: The write payload (select 1) keeps bits [15:0] of the written word and reads back with zero upper bits. The read result (select 2) returns 16 bits in [15:0] with zero upper bits and is 0 after reset.
- R3: Control register (select 3): bit 3 is the interface enable and reads back as written, and bit 0 is go/busy. A control write with bit 0 = 1 and bit 3 = 1 while idle starts a frame, and bit 0 then reads 1 until the frame ends.
- R4: A control write with bit 0 = 1 and bit 3 = 0 issues no frame: bit 0 reads 0 on the next cycle and the clock line never rises.
- R5: A write frame, taken MSB first, is 32 ones, then 01, then 01, then PHY address, then register address, then 10, then the 16 payload bits, with the output enable high for all 64 bits.
- R6: A read frame carries opcode 10 and drives its first 46 bits like R5. It releases the output enable for the last 18 bits (turnaround and data). It samples the data input on the rising edge of the management clock, MSB first, and updates the read result only when the frame completes.
- R7: The management clock has a period of `CLK_DIV` system clocks at 50% duty and stays low while idle. A frame is exactly 64 clock periods, so bit 0 reads 1 for exactly 64*`CLK_DIV` cycles.
- R8: The data output changes only when the management clock falls or a frame ends, and the output enable is low while idle.
- R9: A start written while busy is ignored, and writes to the descriptor or payload during a frame do not alter the frame in flight.
- R10: A control write with bit 3 = 0 during a frame aborts it. On the next cycle busy reads 0 and the clock and output enable are low. The read result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 2 | Register select |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A bench-side PHY model records the output bit and enable at every rising edge of the management clock, and feeds a chosen 16-bit reply during the data phase of reads. Random write frames with varied addresses and payloads separate correct field order and opcode from swapped or shifted fields. Random reads with distinct replies expose off-by-one sampling and bit-order errors. Directed cases (start while disabled, start and descriptor rewrite while busy, abort mid-frame) separate correct gating from a block that leaks new settings into a running frame or leaves the line driven.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_sel,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [5:0] LAST_BIT = 6'd63;
  localparam logic [5:0] TA_BIT   = 6'd46;
  localparam logic [5:0] DATA_BIT = 6'd48;

  logic [4:0]    reg_a, phy_a;
  logic          op_rd, f_rd, en, busy;
  logic [15:0]   wd, rd, cap;
  logic [CW-1:0] cnt;
  logic [5:0]    bitn;
  logic [63:0]   sh;

  wire wr_desc = cfg_we && cfg_sel == 2'd0;
  wire wr_pay  = cfg_we && cfg_sel == 2'd1;
  wire wr_ctrl = cfg_we && cfg_sel == 2'd3;
  wire abort   = wr_ctrl && !cfg_wdata[3];
  wire start   = wr_ctrl && cfg_wdata[3] && cfg_wdata[0] && !busy;
  wire tick    = cnt == CW'(HALF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0; phy_a <= '0; op_rd <= 1'b0; wd <= '0; rd <= '0; cap <= '0;
      en <= 1'b0; busy <= 1'b0; mdc <= 1'b0; cnt <= '0; bitn <= '0;
      f_rd <= 1'b0; sh <= '1;
    end else begin
      if (wr_desc) {op_rd, phy_a, reg_a} <= cfg_wdata[10:0];
      if (wr_pay) wd <= cfg_wdata[15:0];
      if (wr_ctrl) en <= cfg_wdata[3];
      if (abort) begin
        busy <= 1'b0;
        mdc  <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        mdc  <= 1'b0;
        cnt  <= '0;
        bitn <= '0;
        f_rd <= op_rd;
        sh   <= {32'hFFFF_FFFF, 2'b01, op_rd ? 2'b10 : 2'b01, phy_a, reg_a,
                 2'b10, op_rd ? 16'hFFFF : wd};
      end else if (busy) begin
        if (tick) begin
          cnt <= '0;
          mdc <= !mdc;
          if (!mdc) begin
            if (f_rd && bitn >= DATA_BIT) cap <= {cap[14:0], mdio_i};
          end else if (bitn == LAST_BIT) begin
            busy <= 1'b0;
            if (f_rd) rd <= cap;
          end else begin
            bitn <= bitn + 6'd1;
            sh   <= {sh[62:0], 1'b1};
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign mdio_o  = busy ? sh[63] : 1'b1;
  assign mdio_oe = busy && !(f_rd && bitn >= TA_BIT);

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = {21'd0, op_rd, phy_a, reg_a};
      2'd1:    cfg_rdata = {16'd0, wd};
      2'd2:    cfg_rdata = {16'd0, rd};
      default: cfg_rdata = {28'd0, en, 2'b00, busy};
    endcase
  end
endmodule

module mdio_master_chk #(
  parameter int CLK_DIV = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_wdata
);
  localparam int FRAME_CYC = 64 * CLK_DIV;
  int cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else if (busy) cyc <= cyc + 1;
    else cyc <= 0;
  end

  wire abort_req = cfg_we && cfg_sel == 2'd3 && !cfg_wdata[3];
  wire off_start = cfg_we && cfg_sel == 2'd3 && cfg_wdata[0] && !cfg_wdata[3];

  // R4
  off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_start |=> !busy);
  // R7
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(abort_req)) |-> cyc == FRAME_CYC);
  // R7
  idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R8
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  // R8
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_o != $past(mdio_o)) |-> ($fell(mdc) || $fell(busy)));
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!busy && !mdc && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk #(.CLK_DIV(CLK_DIV)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int DIV = 40;
  localparam int NCYC = 64 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, mdio_i;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_master #(.CLK_DIV(DIV)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, rcount = 0;
  logic [63:0] obit, oebit;
  logic [15:0] phy_val = '0;

  always @(posedge mdc) begin
    if (rcount < 64) begin
      obit[63-rcount]  = mdio_o;
      oebit[63-rcount] = mdio_oe;
    end
    rcount++;
  end
  assign mdio_i = (rcount >= 48 && rcount < 64) ? phy_val[63-rcount] : 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_sel = s; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    cfg_sel = s; #1; d = cfg_rdata;
  endtask

  function automatic logic [63:0] exp_frame(input logic op, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, op ? 2'b10 : 2'b01, phy, rg, 2'b10, wd};
  endfunction

  task automatic frame(input logic op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] pv, input bit disturb);
    int n;
    bit done;
    logic [31:0] d;
    logic [63:0] m, e;
    wr(2'd0, {21'd0, op, phy, rg});
    wr(2'd1, {16'hABCD, wd});
    phy_val = pv; rcount = 0;
    @(negedge clk); cfg_sel = 2'd3; cfg_wdata = 32'h9; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    n = 0; done = 0;
    while (!done && n < 100000) begin
      if (disturb && n == 100) begin cfg_sel = 2'd3; cfg_wdata = 32'h9; cfg_we = 1'b1; end
      else if (disturb && n == 101) begin cfg_sel = 2'd0; cfg_wdata = {21'd0, ~op, ~phy, ~rg}; cfg_we = 1'b1; end
      else if (disturb && n == 102) begin cfg_sel = 2'd1; cfg_wdata = {16'd0, ~wd}; cfg_we = 1'b1; end
      else begin cfg_we = 1'b0; rd(2'd3, d); if (!d[0]) done = 1; end
      if (!done) begin n++; @(negedge clk); end
    end
    chk(n == NCYC, "R7 busy length", 64'(n), 64'(NCYC));
    chk(rcount == 64, "R7 clock periods", 64'(rcount), 64'd64);
    m = op ? ~64'h3FFFF : '1;
    e = exp_frame(op, phy, rg, wd);
    chk((obit & m) == (e & m), op ? "R6 read frame bits" : (disturb ? "R9 frame kept" : "R5 write frame bits"), obit & m, e & m);
    chk(oebit == m, op ? "R6 output enable" : "R5 output enable", oebit, m);
    if (op) begin
      rd(2'd2, d);
      chk(d == {16'd0, pv}, "R6 read result", 64'(d), 64'(pv));
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] last_rd;
    int rc0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd3, d); chk(d == 0, "R3 reset control", 64'(d), 0);
    rd(2'd2, d); chk(d == 0, "R2 reset read result", 64'(d), 0);
    chk(!mdc && !mdio_oe, "R8 reset lines", {62'd0, mdc, mdio_oe}, 0);

    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk(d == 32'h7FF, "R1 descriptor readback", 64'(d), 64'h7FF);
    wr(2'd0, 32'h0000_0421); rd(2'd0, d); chk(d == 32'h421, "R1 field positions", 64'(d), 64'h421);
    wr(2'd1, 32'hFFFF_1234); rd(2'd1, d); chk(d == 32'h1234, "R2 payload readback", 64'(d), 64'h1234);
    wr(2'd3, 32'h8); rd(2'd3, d); chk(d == 32'h8, "R3 enable readback", 64'(d), 64'h8);

    rcount = 0;
    wr(2'd3, 32'h1); rd(2'd3, d);
    chk(d == 0, "R4 disabled start status", 64'(d), 0);
    repeat (200) @(negedge clk);
    chk(rcount == 0 && !mdc, "R4 no clock when disabled", 64'(rcount), 0);

    frame(1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0, 0);
    frame(1'b1, 5'h1F, 5'h1F, 16'h0, 16'h8001, 0);
    frame(1'b0, 5'h05, 5'h0A, 16'h1234, 16'h0, 1);
    frame(1'b1, 5'h0C, 5'h11, 16'h0, 16'h6C39, 1);
    for (int i = 0; i < 10; i++) begin
      logic op;
      op = 1'($urandom);
      frame(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 0);
    end

    rd(2'd2, d); last_rd = d[15:0];
    frame(1'b1, 5'h03, 5'h02, 16'h0, 16'hBEEF, 0);
    rd(2'd2, d); last_rd = d[15:0];
    wr(2'd0, {21'd0, 1'b1, 5'h04, 5'h07});
    phy_val = 16'h1357; rcount = 0;
    wr(2'd3, 32'h9);
    repeat (NCYC - 300) @(negedge clk);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk(d == 0, "R10 abort clears busy", 64'(d), 0);
    chk(!mdc && !mdio_oe, "R10 abort lines low", {62'd0, mdc, mdio_oe}, 0);
    rc0 = rcount;
    repeat (200) @(negedge clk);
    chk(rcount == rc0, "R10 no clock after abort", 64'(rcount), 64'(rc0));
    rd(2'd2, d); chk(d[15:0] == last_rd, "R10 read result kept", 64'(d), 64'(last_rd));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule